// File: doc/BRIEF.md
# Uncached IO Bypass Tag Router

This block sits beside a cache and carries non-cacheable (IO) traffic from several requesters straight to memory. It also shares the single memory request port with the cache's own miss and writeback traffic. A request marked as IO is picked from the requester ports, with the lowest index winning. Its tag is extended with the requester's index and with one routing bit, and the result is offered to memory. Cached-path requests come in on a separate channel and are preferred whenever both sources are waiting. The exception is a memory offer that has already stalled: it keeps the port until memory takes it.

On the return side, the routing bit of each memory response picks the destination. A clear bit sends the response to the cached path. A set bit means the low index bits name the requester, and the bits above them are handed back as that requester's own tag. When write acknowledgement is enabled, an IO write is acknowledged to its requester in the same cycle memory accepts it. Reads get no early reply; their only reply comes from memory.

Top module: `iob_bypass_router`

## Requirements
- R1: A forwarded bypass request carries memory tag {1'b1, requester tag, requester index}: bit CTAG_W (the MSB) is 1, bits [IDX_W-1:0] hold the index, and the bits above them hold the requester tag. This equals (tag << IDX_W) + index below the MSB.
- R2: A cached-path request is forwarded with memory tag {1'b0, cache tag}. When no offer is held, a valid cached request wins over any bypass request.
- R3: Among requesters with both valid and IO set, the lowest index is forwarded.
- R4: A request without the IO flag never receives ready and never reaches memory.
- R5: A requester's ready is high only in the cycle its request is offered to memory with mem_req_ready high, and at most one requester is consumed per cycle.
- R6: While the memory offer is valid and not ready, the next cycle offers the same request (same valid, tag and address), even if a higher-priority source appears.
- R7: A memory response with MSB 1 is delivered only to the requester named by its low IDX_W bits. It carries the tag from the bits above and the data unchanged.
- R8: A memory response with MSB 0 goes to the cached path with its low CTAG_W bits as tag, and mem_rsp_ready equals cache_rsp_ready.
- R9: With WRITE_ACK=1, an accepted bypass write makes rsp_valid of that requester high in the same cycle, with the original tag and zero data. An accepted bypass read makes no response.
- R10: If an acknowledgement and a bypass memory response target the same requester in one cycle, the acknowledgement is delivered and mem_rsp_ready is low. The memory response is delivered once the clash is gone.
- R11: During and right after reset, with idle inputs, no memory request, no response and no requester ready is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | NUM_REQ | Requester request valid |
| req_ready | output | NUM_REQ | Requester request consumed |
| req_io | input | NUM_REQ | Request is non-cacheable |
| req_write | input | NUM_REQ | Request is a write |
| req_addr | input | NUM_REQ*ADDR_W | Requester addresses, lane i at [i*ADDR_W +: ADDR_W] |
| req_data | input | NUM_REQ*DATA_W | Requester write data |
| req_tag | input | NUM_REQ*TAG_W | Requester tags |
| rsp_valid | output | NUM_REQ | Response to requester (always accepted) |
| rsp_tag | output | NUM_REQ*TAG_W | Response tag per requester |
| rsp_data | output | NUM_REQ*DATA_W | Response data per requester |
| cache_req_valid | input | 1 | Cached-path request valid |
| cache_req_ready | output | 1 | Cached-path request accepted |
| cache_req_write | input | 1 | Cached-path write |
| cache_req_addr | input | ADDR_W | Cached-path address |
| cache_req_data | input | DATA_W | Cached-path write data |
| cache_req_tag | input | TAG_W+IDX_W | Cached-path tag |
| cache_rsp_valid | output | 1 | Response to cached path |
| cache_rsp_ready | input | 1 | Cached path takes response |
| cache_rsp_tag | output | TAG_W+IDX_W | Cached-path response tag |
| cache_rsp_data | output | DATA_W | Cached-path response data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_data | output | DATA_W | Memory write data |
| mem_req_tag | output | TAG_W+IDX_W+1 | Memory tag with routing MSB |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Memory response taken |
| mem_rsp_tag | input | TAG_W+IDX_W+1 | Memory response tag |
| mem_rsp_data | input | DATA_W | Memory response data |

## Verification
The only state is the hold of a stalled offer: the winning source and requester index. A wrong hold shows at the memory port one cycle after a stall, as a changed tag or address or a dropped valid. It also shows as a ready given to a requester memory never took. Errors in folding or unfolding a tag show in the same cycle, as a response on the wrong requester lane or with the index bits left inside the returned tag. A bad acknowledgement clash rule shows as two answers racing for one lane, or as a memory response being lost.

// File: rtl/iob_pkg.sv
package iob_pkg;
  typedef enum logic {
    SRC_CACHE  = 1'b0,
    SRC_BYPASS = 1'b1
  } src_e;
endpackage

// File: rtl/iob_pick.sv
module iob_pick #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] cand,
  input  logic               stalled,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic             held_q;
  logic [IDX_W-1:0] held_idx_q;

  always_comb begin
    any = 1'b0;
    idx = '0;
    if (held_q) begin
      idx = held_idx_q;
      any = cand[held_idx_q];
    end else begin
      for (int k = NUM_REQ - 1; k >= 0; k--) begin
        if (cand[k]) begin
          any = 1'b1;
          idx = IDX_W'(k);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_idx_q <= '0;
    end else begin
      held_q     <= stalled;
      held_idx_q <= idx;
    end
  end
endmodule

// File: rtl/iob_merge.sv
module iob_merge
  import iob_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic v_cache,
  input  logic v_bypass,
  input  logic take,
  output src_e sel,
  output logic valid
);
  logic lock_q;
  src_e lock_sel_q;

  always_comb begin
    if (lock_q)       sel = lock_sel_q;
    else if (v_cache) sel = SRC_CACHE;
    else              sel = SRC_BYPASS;
    valid = (sel == SRC_CACHE) ? v_cache : v_bypass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_sel_q <= SRC_CACHE;
    end else begin
      lock_q     <= valid && !take;
      lock_sel_q <= sel;
    end
  end
endmodule

// File: rtl/iob_rsp_split.sv
module iob_rsp_split
  import iob_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_REQ),
  localparam int CTAG_W = TAG_W + IDX_W,
  localparam int MTAG_W = CTAG_W + 1
) (
  input  logic                      mem_rsp_valid,
  input  logic [MTAG_W-1:0]         mem_rsp_tag,
  input  logic [DATA_W-1:0]         mem_rsp_data,
  output logic                      mem_rsp_ready,
  input  logic                      ack_fire,
  input  logic [IDX_W-1:0]          ack_idx,
  input  logic [TAG_W-1:0]          ack_tag,
  output logic                      cache_rsp_valid,
  input  logic                      cache_rsp_ready,
  output logic [CTAG_W-1:0]         cache_rsp_tag,
  output logic [DATA_W-1:0]         cache_rsp_data,
  output logic [NUM_REQ-1:0]        rsp_valid,
  output logic [NUM_REQ*TAG_W-1:0]  rsp_tag,
  output logic [NUM_REQ*DATA_W-1:0] rsp_data
);
  function automatic logic [IDX_W-1:0] lane_of(input logic [MTAG_W-1:0] t);
    return t[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] user_tag_of(input logic [MTAG_W-1:0] t);
    return TAG_W'(t[CTAG_W-1:0] >> IDX_W);
  endfunction

  logic             to_bypass;
  logic [IDX_W-1:0] byp_lane;
  logic             clash;

  assign to_bypass = mem_rsp_tag[MTAG_W-1] == SRC_BYPASS;
  assign byp_lane  = lane_of(mem_rsp_tag);
  assign clash     = ack_fire && to_bypass && (ack_idx == byp_lane);

  assign cache_rsp_valid = mem_rsp_valid && !to_bypass;
  assign cache_rsp_tag   = mem_rsp_tag[CTAG_W-1:0];
  assign cache_rsp_data  = mem_rsp_data;
  assign mem_rsp_ready   = to_bypass ? !clash : cache_rsp_ready;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_lane
    logic ack_here;
    logic mem_here;
    assign ack_here = ack_fire && (ack_idx == IDX_W'(g));
    assign mem_here = mem_rsp_valid && to_bypass && (byp_lane == IDX_W'(g)) && !clash;
    assign rsp_valid[g] = ack_here || mem_here;
    assign rsp_tag[g*TAG_W +: TAG_W]    = ack_here ? ack_tag : user_tag_of(mem_rsp_tag);
    assign rsp_data[g*DATA_W +: DATA_W] = ack_here ? '0 : mem_rsp_data;
  end
endmodule

// File: rtl/iob_bypass_router.sv
module iob_bypass_router
  import iob_pkg::*;
#(
  parameter int   NUM_REQ   = 4,
  parameter int   TAG_W     = 8,
  parameter int   ADDR_W    = 32,
  parameter int   DATA_W    = 32,
  parameter logic WRITE_ACK = 1'b1,
  localparam int  IDX_W     = $clog2(NUM_REQ),
  localparam int  CTAG_W    = TAG_W + IDX_W,
  localparam int  MTAG_W    = CTAG_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_valid,
  output logic [NUM_REQ-1:0]        req_ready,
  input  logic [NUM_REQ-1:0]        req_io,
  input  logic [NUM_REQ-1:0]        req_write,
  input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
  input  logic [NUM_REQ*DATA_W-1:0] req_data,
  input  logic [NUM_REQ*TAG_W-1:0]  req_tag,
  output logic [NUM_REQ-1:0]        rsp_valid,
  output logic [NUM_REQ*TAG_W-1:0]  rsp_tag,
  output logic [NUM_REQ*DATA_W-1:0] rsp_data,
  input  logic                      cache_req_valid,
  output logic                      cache_req_ready,
  input  logic                      cache_req_write,
  input  logic [ADDR_W-1:0]         cache_req_addr,
  input  logic [DATA_W-1:0]         cache_req_data,
  input  logic [CTAG_W-1:0]         cache_req_tag,
  output logic                      cache_rsp_valid,
  input  logic                      cache_rsp_ready,
  output logic [CTAG_W-1:0]         cache_rsp_tag,
  output logic [DATA_W-1:0]         cache_rsp_data,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_req_write,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic [DATA_W-1:0]         mem_req_data,
  output logic [MTAG_W-1:0]         mem_req_tag,
  input  logic                      mem_rsp_valid,
  output logic                      mem_rsp_ready,
  input  logic [MTAG_W-1:0]         mem_rsp_tag,
  input  logic [DATA_W-1:0]         mem_rsp_data
);
  function automatic logic [CTAG_W-1:0] fold_tag(input logic [TAG_W-1:0] t,
                                                 input logic [IDX_W-1:0] i);
    return (CTAG_W'(t) << IDX_W) + CTAG_W'(i);
  endfunction

  logic             byp_any;
  logic [IDX_W-1:0] byp_idx;
  src_e             sel;
  logic             byp_stall;
  logic             byp_take;
  logic             ack_fire;
  logic [TAG_W-1:0] byp_tag;

  assign byp_tag   = req_tag[byp_idx*TAG_W +: TAG_W];
  assign byp_stall = (sel == SRC_BYPASS) && mem_req_valid && !mem_req_ready;
  assign byp_take  = (sel == SRC_BYPASS) && byp_any && mem_req_ready;
  assign ack_fire  = WRITE_ACK && byp_take && req_write[byp_idx];

  iob_pick #(.NUM_REQ(NUM_REQ)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (req_valid & req_io),
    .stalled (byp_stall),
    .any     (byp_any),
    .idx     (byp_idx)
  );

  iob_merge u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .v_cache  (cache_req_valid),
    .v_bypass (byp_any),
    .take     (mem_req_ready),
    .sel      (sel),
    .valid    (mem_req_valid)
  );

  always_comb begin
    if (sel == SRC_CACHE) begin
      mem_req_write = cache_req_write;
      mem_req_addr  = cache_req_addr;
      mem_req_data  = cache_req_data;
      mem_req_tag   = {SRC_CACHE, cache_req_tag};
    end else begin
      mem_req_write = req_write[byp_idx];
      mem_req_addr  = req_addr[byp_idx*ADDR_W +: ADDR_W];
      mem_req_data  = req_data[byp_idx*DATA_W +: DATA_W];
      mem_req_tag   = {SRC_BYPASS, fold_tag(byp_tag, byp_idx)};
    end
  end

  assign cache_req_ready = (sel == SRC_CACHE) && mem_req_ready;

  always_comb begin
    req_ready = '0;
    if (byp_take) req_ready[byp_idx] = 1'b1;
  end

  iob_rsp_split #(.NUM_REQ(NUM_REQ), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_split (
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_tag     (mem_rsp_tag),
    .mem_rsp_data    (mem_rsp_data),
    .mem_rsp_ready   (mem_rsp_ready),
    .ack_fire        (ack_fire),
    .ack_idx         (byp_idx),
    .ack_tag         (byp_tag),
    .cache_rsp_valid (cache_rsp_valid),
    .cache_rsp_ready (cache_rsp_ready),
    .cache_rsp_tag   (cache_rsp_tag),
    .cache_rsp_data  (cache_rsp_data),
    .rsp_valid       (rsp_valid),
    .rsp_tag         (rsp_tag),
    .rsp_data        (rsp_data)
  );
endmodule

// File: rtl/iob_router_chk.sv
module iob_router_chk #(
  parameter int   NUM_REQ   = 4,
  parameter int   TAG_W     = 8,
  parameter int   ADDR_W    = 32,
  parameter int   DATA_W    = 32,
  parameter logic WRITE_ACK = 1'b1,
  localparam int  IDX_W     = $clog2(NUM_REQ),
  localparam int  CTAG_W    = TAG_W + IDX_W,
  localparam int  MTAG_W    = CTAG_W + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_REQ-1:0]        req_valid,
  input logic [NUM_REQ-1:0]        req_ready,
  input logic [NUM_REQ-1:0]        req_io,
  input logic [NUM_REQ-1:0]        req_write,
  input logic [NUM_REQ-1:0]        rsp_valid,
  input logic [NUM_REQ*TAG_W-1:0]  rsp_tag,
  input logic                      cache_req_valid,
  input logic                      mem_req_valid,
  input logic                      mem_req_ready,
  input logic [ADDR_W-1:0]         mem_req_addr,
  input logic [MTAG_W-1:0]         mem_req_tag,
  input logic                      mem_rsp_valid,
  input logic                      mem_rsp_ready,
  input logic [MTAG_W-1:0]         mem_rsp_tag
);
  logic [NUM_REQ-1:0] taken;
  assign taken = req_valid & req_ready;

  assert_no_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken & ~req_io) == '0);

  assert_single_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken) && ((taken == '0) || (mem_req_valid && mem_req_ready)));

  assert_cache_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_tag[MTAG_W-1]) |-> cache_req_valid);

  assert_hold_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_tag) && $stable(mem_req_addr)));

  assert_rsp_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready && mem_rsp_tag[MTAG_W-1]) |->
      (rsp_valid[mem_rsp_tag[IDX_W-1:0]] &&
       rsp_tag[mem_rsp_tag[IDX_W-1:0]*TAG_W +: TAG_W] == mem_rsp_tag[CTAG_W-1:IDX_W]));

  assert_write_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_ACK && ((taken & req_write) != '0)) |-> ((rsp_valid & taken) != '0));
endmodule

bind iob_bypass_router iob_router_chk #(
  .NUM_REQ(NUM_REQ), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_ACK(WRITE_ACK)
) u_chk (.*);

// File: tb/tb_iob_bypass_router.sv
module tb_iob_bypass_router;
  localparam int N = 4, TW = 8, AW = 32, DW = 32;
  localparam int CTW = 10, MTW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] req_valid, req_ready, req_io, req_write, rsp_valid;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_data, rsp_data;
  logic [N*TW-1:0] req_tag, rsp_tag;
  logic cache_req_valid, cache_req_ready, cache_req_write;
  logic [AW-1:0] cache_req_addr, mem_req_addr;
  logic [DW-1:0] cache_req_data, cache_rsp_data, mem_req_data, mem_rsp_data;
  logic [CTW-1:0] cache_req_tag, cache_rsp_tag;
  logic cache_rsp_valid, cache_rsp_ready;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid, mem_rsp_ready;
  logic [MTW-1:0] mem_req_tag, mem_rsp_tag;

  iob_bypass_router dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] vld, io, wr;
    logic       cv, mv;
    logic [10:0] tag;
    logic [3:0] rdy, ack;
  } vec_t;

  // Expected bypass tag for lane i: {1, 8'hA0+i, i}
  localparam vec_t VECS [9] = '{
    '{4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 11'h000, 4'b0000, 4'b0000}, // R4 idle
    '{4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b1, 11'h680, 4'b0001, 4'b0000}, // R1 R9 read
    '{4'b0100, 4'b0100, 4'b0100, 1'b0, 1'b1, 11'h68A, 4'b0100, 4'b0100}, // R9 write ack
    '{4'b1010, 4'b1010, 4'b0000, 1'b0, 1'b1, 11'h685, 4'b0010, 4'b0000}, // R3
    '{4'b1111, 4'b1000, 4'b0000, 1'b0, 1'b1, 11'h68F, 4'b1000, 4'b0000}, // R4 R5
    '{4'b0111, 4'b0000, 4'b0000, 1'b0, 1'b0, 11'h000, 4'b0000, 4'b0000}, // R4
    '{4'b1001, 4'b1001, 4'b1001, 1'b1, 1'b1, 11'h155, 4'b0000, 4'b0000}, // R2
    '{4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 11'h155, 4'b0000, 4'b0000}, // R2
    '{4'b1100, 4'b1100, 4'b1000, 1'b0, 1'b1, 11'h68A, 4'b0100, 4'b0000}  // R3
  };

  task automatic idle();
    req_valid = '0; req_io = '0; req_write = '0;
    cache_req_valid = 0; mem_req_ready = 1; mem_rsp_valid = 0;
    mem_rsp_tag = '0; mem_rsp_data = '0; cache_rsp_ready = 1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      req_tag[i*TW +: TW]  = 8'hA0 + 8'(i);
      req_addr[i*AW +: AW] = 32'h1000 * i;
      req_data[i*DW +: DW] = 32'hC0DE_0000 + i;
    end
    cache_req_write = 0; cache_req_addr = 32'h8000; cache_req_data = 32'h5555;
    cache_req_tag = 10'h155;
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R11 mem_req_valid in reset", mem_req_valid, 0);
    chk("R11 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R11 req_ready after reset", req_ready, 0);
    chk("R11 mem_req_valid after reset", mem_req_valid, 0);

    foreach (VECS[v]) begin
      @(negedge clk);
      idle();
      req_valid = VECS[v].vld; req_io = VECS[v].io; req_write = VECS[v].wr;
      cache_req_valid = VECS[v].cv;
      #1;
      chk($sformatf("R1 R2 R3 vec%0d mem_req_valid", v), mem_req_valid, VECS[v].mv);
      if (VECS[v].mv) chk($sformatf("R1 R2 vec%0d mem_req_tag", v), mem_req_tag, VECS[v].tag);
      chk($sformatf("R4 R5 vec%0d req_ready", v), req_ready, VECS[v].rdy);
      chk($sformatf("R9 vec%0d rsp_valid", v), rsp_valid, VECS[v].ack);
      if (VECS[v].ack[2]) begin
        chk("R9 ack tag", rsp_tag[2*TW +: TW], 8'hA2);
        chk("R9 ack data", rsp_data[2*DW +: DW], 0);
      end
    end

    // R6: stalled bypass offer holds against later higher-priority sources
    @(negedge clk); idle();
    req_valid = 4'b0100; req_io = 4'b0100; mem_req_ready = 0;
    #1;
    chk("R6 stalled valid", mem_req_valid, 1);
    chk("R5 no ready while stalled", req_ready, 0);
    @(negedge clk);
    req_valid = 4'b0101; req_io = 4'b0101; cache_req_valid = 1;
    #1;
    chk("R6 held tag", mem_req_tag, 11'h68A);
    chk("R6 held addr", mem_req_addr, 32'h2000);
    chk("R6 cache waits", cache_req_ready, 0);
    mem_req_ready = 1; #1;
    chk("R5 consume held", req_ready, 4'b0100);
    @(negedge clk);
    req_valid = 4'b0001; req_io = 4'b0001; #1;
    chk("R2 cache wins after release", mem_req_tag, 11'h155);
    chk("R2 bypass not taken", req_ready, 0);

    // R7: bypass response to lane 3, tag 5C
    @(negedge clk); idle();
    mem_rsp_valid = 1; mem_rsp_tag = 11'h573; mem_rsp_data = 32'hDEADBEEF; #1;
    chk("R7 rsp lane", rsp_valid, 4'b1000);
    chk("R7 rsp tag", rsp_tag[3*TW +: TW], 8'h5C);
    chk("R7 rsp data", rsp_data[3*DW +: DW], 32'hDEADBEEF);
    chk("R7 mem_rsp_ready", mem_rsp_ready, 1);
    chk("R7 cache untouched", cache_rsp_valid, 0);

    // R8: cached-path response with back-pressure
    @(negedge clk); idle();
    mem_rsp_valid = 1; mem_rsp_tag = 11'h0AB; cache_rsp_ready = 0; #1;
    chk("R8 cache valid", cache_rsp_valid, 1);
    chk("R8 cache tag", cache_rsp_tag, 10'h0AB);
    chk("R8 ready follows", mem_rsp_ready, 0);
    chk("R8 no requester rsp", rsp_valid, 0);
    cache_rsp_ready = 1; #1;
    chk("R8 ready follows high", mem_rsp_ready, 1);

    // R10: ack and memory response clash on lane 1
    @(negedge clk); idle();
    mem_rsp_valid = 1; mem_rsp_tag = 11'h4CD; mem_rsp_data = 32'h1234;
    req_valid = 4'b0010; req_io = 4'b0010; req_write = 4'b0010; #1;
    chk("R10 ack wins lane", rsp_tag[1*TW +: TW], 8'hA1);
    chk("R10 mem stalled", mem_rsp_ready, 0);
    @(negedge clk);
    req_valid = 0; req_io = 0; req_write = 0; #1;
    chk("R10 mem rsp later", rsp_tag[1*TW +: TW], 8'h33);
    chk("R10 mem rsp data", rsp_data[1*DW +: DW], 32'h1234);
    chk("R10 mem ready", mem_rsp_ready, 1);

    @(negedge clk); idle();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule